// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block keeps the operating mode of a CAN controller core and the bit-timing settings that the protocol engine uses. Software reaches it through a 32-bit register port: a control register that either forces the core back into configuration or enables it, a mode-select register, a prescaler register, a bit-timing register and a read-only status register. The current mode is driven to the protocol engine as a two-bit code, and the timing fields are driven out as separate buses.

The core starts in configuration mode. The timing registers accept writes only there, so the engine never sees its timing change while it is on the bus. Enabling the core moves it to normal, loopback or sleep mode according to mode-select. The status register shows which mode is in effect. A wake input stands in for bus activity and brings a sleeping core back to normal mode. One-cycle event pulses mark the moments of entering sleep and waking.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, status (offset 0x18) reads exactly 0x00000001, mode_out is 0, and mode-select, prescaler and bit-timing all read zero.
- R2: A control write (offset 0x00) with bit 0 set forces configuration mode and clears mode-select. This holds even when bit 1 is also set in the same write. A control write with both bits clear also returns the core to configuration mode, but mode-select keeps its value.
- R3: A control write with bit 1 set and bit 0 clear, made while in configuration mode, enters the mode chosen by mode-select. Mode-select bit 1 chooses loopback, and this wins over bit 0. Bit 0 alone chooses sleep. A value of 0 chooses normal. The same write made outside configuration mode changes nothing.
- R4: Status bit 3 flags normal, bit 2 sleep, bit 1 loopback and bit 0 configuration. Exactly one of these bits is set, and all other status bits read zero. The control register reads zero.
- R5: In configuration mode, a write to offset 0x08 stores the prescaler from bits 7:0. A write to offset 0x0C stores time segment 1 from bits 3:0, time segment 2 from bits 6:4 and jump width from bits 8:7. Each field is stored as its value minus one. The unused upper bits read zero, and brp_out, ts1_out, ts2_out and sjw_out show the stored fields.
- R6: Writes to offsets 0x08 and 0x0C made outside configuration mode are ignored. Both registers keep and read back their previous values.
- R7: Mode-select at offset 0x04 stores bits 1:0 in any mode and reads them back. Writing the value 1 while in normal mode puts the core into sleep.
- R8: Each entry into sleep raises sleep_evt for exactly one cycle.
- R9: In sleep mode, with no register write in that cycle, wake_in returns the core to normal mode and raises wake_evt for one cycle. In any other mode, wake_in has no effect.
- R10: mode_out encodes the mode as 0 for configuration, 1 for normal, 2 for loopback and 3 for sleep.
- R11: Reads from offsets that are not mapped return zero. Writes to them change no register and no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| wake_in | input | 1 | Bus activity seen while asleep |
| mode_out | output | 2 | Mode in effect (encoding in R10) |
| sleep_evt | output | 1 | One-cycle pulse on entry to sleep |
| wake_evt | output | 1 | One-cycle pulse on wake from sleep |
| brp_out | output | 8 | Prescaler minus one |
| ts1_out | output | 4 | Time segment 1 minus one |
| ts2_out | output | 3 | Time segment 2 minus one |
| sjw_out | output | 2 | Jump width minus one |

## Verification
Every write and every wake takes effect at the first rising edge on which it is presented. The new mode, register contents and event pulses are all visible in the cycle right after that edge, and the event pulses last for exactly that one cycle. The bench changes its inputs on the falling edge. It updates its own model for the coming edge, then samples every output and every readable offset shortly after the rising edge. That way each result is compared in the one cycle where it is due, and a pulse that is late or lasts too long is caught.

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              wake_in,
  output logic [1:0]        mode_out,
  output logic              sleep_evt,
  output logic              wake_evt,
  output logic [7:0]        brp_out,
  output logic [3:0]        ts1_out,
  output logic [2:0]        ts2_out,
  output logic [1:0]        sjw_out
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MSEL = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_BRP  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_BTR  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h18);

  typedef enum logic [1:0] {M_CFG = 2'd0, M_NRM = 2'd1, M_LPB = 2'd2, M_SLP = 2'd3} mode_t;

  mode_t      mode_q;
  logic [1:0] msel_q;
  logic [7:0] brp_q;
  logic [8:0] btr_q;
  mode_t      target;
  logic [3:0] stat_w;
  logic       in_cfg;

  assign in_cfg = (mode_q == M_CFG);
  assign target = msel_q[1] ? M_LPB : (msel_q[0] ? M_SLP : M_NRM);
  assign stat_w = {mode_q == M_NRM, mode_q == M_SLP, mode_q == M_LPB, in_cfg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_CFG;
      msel_q    <= '0;
      brp_q     <= '0;
      btr_q     <= '0;
      sleep_evt <= 1'b0;
      wake_evt  <= 1'b0;
    end else begin
      sleep_evt <= 1'b0;
      wake_evt  <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            if (wr_data[0]) begin
              mode_q <= M_CFG;
              msel_q <= '0;
            end else if (!wr_data[1]) begin
              mode_q <= M_CFG;
            end else if (in_cfg) begin
              mode_q    <= target;
              sleep_evt <= (target == M_SLP);
            end
          end
          A_MSEL: begin
            msel_q <= wr_data[1:0];
            if (mode_q == M_NRM && wr_data[1:0] == 2'b01) begin
              mode_q    <= M_SLP;
              sleep_evt <= 1'b1;
            end
          end
          A_BRP: if (in_cfg) brp_q <= wr_data[7:0];
          A_BTR: if (in_cfg) btr_q <= wr_data[8:0];
          default: ;
        endcase
      end else if (mode_q == M_SLP && wake_in) begin
        mode_q   <= M_NRM;
        wake_evt <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_MSEL:  rd_data = {30'd0, msel_q};
      A_BRP:   rd_data = {24'd0, brp_q};
      A_BTR:   rd_data = {23'd0, btr_q};
      A_STAT:  rd_data = {28'd0, stat_w};
      default: rd_data = '0;
    endcase
  end

  assign mode_out = mode_q;
  assign brp_out  = brp_q;
  assign ts1_out  = btr_q[3:0];
  assign ts2_out  = btr_q[6:4];
  assign sjw_out  = btr_q[8:7];
endmodule

module can_mode_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wake_in,
  input logic [1:0]        mode_out,
  input logic              sleep_evt,
  input logic              wake_evt,
  input logic [7:0]        brp_out,
  input logic [3:0]        ts1_out,
  input logic [2:0]        ts2_out,
  input logic [1:0]        sjw_out,
  input logic [3:0]        stat_w
);
  p_soft_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_data[0]) |=> (mode_out == 2'd0));

  p_status_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat_w) == 1);

  p_timing_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out != 2'd0) |=> $stable({brp_out, sjw_out, ts2_out, ts1_out}));

  p_sleep_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_evt |-> (mode_out == 2'd3 && !wake_evt));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'd3 && wake_in && !wr_en) |=> (mode_out == 2'd1 && wake_evt));

  p_no_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out != 2'd3 && !wr_en) |=> $stable(mode_out));
endmodule

bind can_mode_seq can_mode_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wake_in(wake_in), .mode_out(mode_out), .sleep_evt(sleep_evt), .wake_evt(wake_evt),
  .brp_out(brp_out), .ts1_out(ts1_out), .ts2_out(ts2_out), .sjw_out(sjw_out),
  .stat_w(stat_w)
);

// File: tb/test_can_mode_seq.sv
`timescale 1ns/100ps
module test_can_mode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, wake_in = 0;
  logic [ADDR_W-1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [1:0] mode_out, sjw_out;
  logic sleep_evt, wake_evt;
  logic [7:0] brp_out;
  logic [3:0] ts1_out;
  logic [2:0] ts2_out;

  int checks = 0, errors = 0;
  logic [1:0] m_mode, m_msel;
  logic [7:0] m_brp;
  logic [8:0] m_btr;
  logic m_sevt, m_wevt;

  can_mode_seq #(.ADDR_W(ADDR_W)) i_can_mode_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wake_in(wake_in), .mode_out(mode_out),
    .sleep_evt(sleep_evt), .wake_evt(wake_evt), .brp_out(brp_out),
    .ts1_out(ts1_out), .ts2_out(ts2_out), .sjw_out(sjw_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_status(input logic [1:0] m);
    case (m)
      2'd0: return 32'h1;
      2'd1: return 32'h8;
      2'd2: return 32'h2;
      default: return 32'h4;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h04: return {30'd0, m_msel};
      8'h08: return {24'd0, m_brp};
      8'h0C: return {23'd0, m_btr};
      8'h18: return exp_status(m_mode);
      default: return 32'h0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] addrs [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h10};
    cmp(tag, "mode_out", {30'd0, mode_out}, {30'd0, m_mode});
    cmp(tag, "sleep_evt", {31'd0, sleep_evt}, {31'd0, m_sevt});
    cmp(tag, "wake_evt", {31'd0, wake_evt}, {31'd0, m_wevt});
    cmp(tag, "timing outs", {15'd0, sjw_out, ts2_out, ts1_out, brp_out}, {15'd0, m_btr, m_brp});
    for (int i = 0; i < 6; i++) begin
      rd_addr = addrs[i];
      #0.5;
      cmp(tag, $sformatf("read %h", addrs[i]), rd_data, exp_read(addrs[i]));
    end
  endtask

  task automatic model(input logic we, input logic [7:0] a, input logic [31:0] d, input logic wk);
    logic [1:0] tgt;
    m_sevt = 0; m_wevt = 0;
    tgt = m_msel[1] ? 2'd2 : (m_msel[0] ? 2'd3 : 2'd1);
    if (we) begin
      case (a)
        8'h00: if (d[0]) begin m_mode = 0; m_msel = 0; end
               else if (!d[1]) m_mode = 0;
               else if (m_mode == 0) begin m_mode = tgt; m_sevt = (tgt == 3); end
        8'h04: begin
                 if (m_mode == 1 && d[1:0] == 2'b01) begin m_mode = 3; m_sevt = 1; end
                 m_msel = d[1:0];
               end
        8'h08: if (m_mode == 0) m_brp = d[7:0];
        8'h0C: if (m_mode == 0) m_btr = d[8:0];
        default: ;
      endcase
    end else if (m_mode == 3 && wk) begin
      m_mode = 1; m_wevt = 1;
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic wk, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; wake_in = wk;
    model(we, a, d, wk);
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] amap [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h2C};
    process::self().srandom(32'd1234);
    m_mode = 0; m_msel = 0; m_brp = 0; m_btr = 0; m_sevt = 0; m_wevt = 0;
    #(CLK_PERIOD * 2 + 2);
    check_all("R1");
    rst_n = 1;
    step(0, 0, 0, 0, "R1");
    // R5 timing writes in configuration mode, upper bits discarded
    step(1, 8'h08, 32'hFFFF_FF3C, 0, "R5");
    step(1, 8'h0C, 32'hFFFF_FEA5, 0, "R5");
    // R3 enable to normal, R10 encoding
    step(1, 8'h00, 32'h2, 0, "R3");
    // R6 locked timing
    step(1, 8'h08, 32'h11, 0, "R6");
    step(1, 8'h0C, 32'h0, 0, "R6");
    // R3 enable while running has no effect
    step(1, 8'h00, 32'h2, 0, "R3");
    // R7 sleep from normal, R8 pulse, R9 wake
    step(1, 8'h04, 32'h1, 0, "R7");
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, "R9");
    // R2 soft reset wins over enable
    step(1, 8'h04, 32'h3, 0, "R7");
    step(1, 8'h00, 32'h3, 0, "R2");
    // R3 loopback priority
    step(1, 8'h04, 32'h3, 0, "R3");
    step(1, 8'h00, 32'h2, 0, "R3");
    step(0, 0, 0, 1, "R9");
    // R2 disable keeps mode-select
    step(1, 8'h00, 32'h0, 0, "R2");
    // R3 enable into sleep
    step(1, 8'h04, 32'h1, 0, "R3");
    step(1, 8'h00, 32'h2, 0, "R8");
    // R11 unmapped write
    step(1, 8'h2C, 32'hFFFF_FFFF, 0, "R11");
    step(1, 8'h00, 32'h1, 0, "R2");
    step(1, 8'h2C, 32'hFFFF_FFFF, 0, "R11");
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = amap[$urandom_range(5)];
      d = (a == 8'h00) ? 32'($urandom_range(3)) : $urandom;
      if (a == 8'h00 && $urandom_range(7) == 0) d = 32'h1;
      step($urandom_range(3) != 0, a, d, $urandom_range(2) == 0, "R4");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule